// File: doc/BRIEF.md
# Virtual Address Region Translation Unit

This block turns a 32-bit virtual address into a 29-bit physical address. It also returns a cacheable flag, a write-through flag, an address-error flag and a TLB-miss flag. The upper address bits and the privilege input place every address in a fixed region. Some regions have a fixed mapping: the physical address is the virtual address with bits [31:29] cleared, and the cache policy comes from the region itself. Other regions are translatable. When translation is enabled, these regions are looked up in a small fully associative TLB, and each TLB entry carries its own page size.

A write port loads one entry per cycle. The global translation enable chooses between the TLB and the fixed mapping that clears the top bits. A mode input selects which page sizes count as legal: the compatible set or the extended set. The global cache-enable and write-through inputs supply the cache policy wherever no TLB entry supplies it. The block returns each result one clock after the request, so it can sit in a pipelined address stage.

Top module: `va_xlate_unit`

## Requirements
- R1: A request with `req_valid` high gives `rsp_valid` high on the next clock, with that request's result. A cycle with `req_valid` low gives `rsp_valid` low on the next clock, and the other response outputs keep their values.
- R2: In privileged mode, 0x8000_0000–0x9FFF_FFFF, 0xA000_0000–0xBFFF_FFFF and 0xE000_0000–0xFFFF_FFFF map to `vaddr[28:0]` without translation. The first range has `cacheable = cache_en` and `wt = cache_en & wt_global`. The other two always return `cacheable = 0` and `wt = 0`. The translatable privileged ranges are 0x0000_0000–0x7FFF_FFFF and 0xC000_0000–0xDFFF_FFFF.
- R3: In user mode, 0x0000_0000–0x7FFF_FFFF is translatable. 0xE000_0000–0xE3FF_FFFF and 0xE500_0000–0xE5FF_FFFF map to `vaddr[28:0]` uncached. 0x8000_0000–0xDFFF_FFFF, 0xE400_0000–0xE4FF_FFFF and 0xE600_0000–0xFFFF_FFFF raise `rsp_aerr`.
- R4: With `xlate_en = 0`, a translatable address maps to `vaddr[28:0]` with `cacheable = cache_en` and `wt = cache_en & wt_global`. It never misses.
- R5: With `xlate_en = 1`, a translatable address that hits gives a physical address built from the entry's physical page bits above the page offset and the virtual offset bits below it. It also gives `cacheable = cache_en & C` and `wt = cacheable & WT`.
- R6: The size code sets the page offset width: 0→10 bits (1 KB), 1→12 (4 KB), 2→13 (8 KB), 3→16 (64 KB), 4→18 (256 KB), 5→20 (1 MB), 6→22 (4 MB), 7→26 (64 MB). A hit compares only the virtual bits above the offset. The entry VPN holds `vaddr[31:10]` and the PPN holds `paddr[28:10]`.
- R7: With `ext_mode = 0`, only codes 0, 1, 3 and 5 are legal. An entry with code 2, 4, 6 or 7 never matches. With `ext_mode = 1`, all eight codes are legal.
- R8: A translatable address with translation on and no matching valid entry gives `rsp_miss = 1` and `rsp_aerr = 0`, with the physical address, `cacheable` and `wt` all 0.
- R9: When several entries match, the entry with the lowest index supplies the result.
- R10: A write loads valid, VPN, PPN, size, C and WT into the indexed entry. A lookup in the same cycle still sees the old contents. Lookups from the next cycle on see the new contents, so writing `valid = 0` removes the entry.
- R11: An address-error response has `rsp_miss`, `cacheable`, `wt` and the physical address all 0.
- R12: After reset, `rsp_valid` is 0, the response outputs are 0, and every TLB entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| xlate_en | input | 1 | Global translation enable |
| ext_mode | input | 1 | 1 = extended page-size set, 0 = compatible set |
| cache_en | input | 1 | Global cache enable |
| wt_global | input | 1 | Global write-through policy for mappings without a TLB entry |
| tlb_wr_en | input | 1 | Write one TLB entry |
| tlb_wr_idx | input | 3 | Entry index to write |
| tlb_wr_valid | input | 1 | Valid bit to store |
| tlb_wr_vpn | input | 22 | Virtual page number, vaddr[31:10] |
| tlb_wr_ppn | input | 19 | Physical page number, paddr[28:10] |
| tlb_wr_size | input | 3 | Page size code |
| tlb_wr_c | input | 1 | Entry cacheable bit |
| tlb_wr_wt | input | 1 | Entry write-through bit |
| rsp_valid | output | 1 | Result valid |
| rsp_paddr | output | 29 | Physical address |
| rsp_cacheable | output | 1 | Access may use the cache |
| rsp_wt | output | 1 | Write-through (1) or copy-back (0) |
| rsp_aerr | output | 1 | Address error |
| rsp_miss | output | 1 | TLB miss |

## Verification
The assertions check properties that hold on every cycle:
- the one-cycle response timing and the idle behaviour;
- the fixed privileged mappings and the always-uncached regions;
- user-mode address errors in the middle range;
- the untranslated mapping when translation is off;
- the clean, all-zero payload of error and miss responses;
- the rule that write-through never appears without cacheable.

Only the bench scenarios can show the behaviours that depend on TLB contents: page-size masking, the rejection of illegal codes in compatible mode, lowest-index priority and the write-then-next-cycle visibility. Its reference model follows each entry it writes and predicts the physical address of every lookup.

// File: rtl/vat_pkg.sv
package vat_pkg;

  parameter int VA_W    = 32;
  parameter int PA_W    = 29;
  parameter int MIN_OFS = 10;
  parameter int SIZE_W  = 3;
  localparam int VPN_W  = VA_W - MIN_OFS;
  localparam int PPN_W  = PA_W - MIN_OFS;

  typedef enum logic [1:0] {
    RG_XLATE    = 2'd0,
    RG_CACHED   = 2'd1,
    RG_UNCACHED = 2'd2,
    RG_ERROR    = 2'd3
  } region_e;

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic [SIZE_W-1:0] size;
    logic              c;
    logic              wt;
  } tlb_entry_t;

  // Offset width in address bits for each size code.
  function automatic int unsigned page_bits(logic [SIZE_W-1:0] code);
    case (code)
      3'd0:    return 10;
      3'd1:    return 12;
      3'd2:    return 13;
      3'd3:    return 16;
      3'd4:    return 18;
      3'd5:    return 20;
      3'd6:    return 22;
      default: return 26;
    endcase
  endfunction

  // Ones on the page-number bits that take part in the compare.
  function automatic logic [VPN_W-1:0] vpn_mask(logic [SIZE_W-1:0] code);
    logic [VPN_W-1:0] ones;
    ones = '1;
    return ones << (page_bits(code) - MIN_OFS);
  endfunction

  function automatic logic size_legal(logic [SIZE_W-1:0] code, logic ext);
    return ext || (code == 3'd0) || (code == 3'd1) || (code == 3'd3) || (code == 3'd5);
  endfunction

endpackage

// File: rtl/vat_region_dec.sv
module vat_region_dec
  import vat_pkg::*;
(
  input  logic [7:0] va_hi,   // vaddr[31:24]
  input  logic       priv,
  output region_e    region
);

  always_comb begin
    region = RG_ERROR;
    if (priv) begin
      case (va_hi[7:5])
        3'd4:    region = RG_CACHED;
        3'd5:    region = RG_UNCACHED;
        3'd7:    region = RG_UNCACHED;
        default: region = RG_XLATE;
      endcase
    end else if (!va_hi[7]) begin
      region = RG_XLATE;
    end else if (va_hi[7:5] == 3'd7) begin
      if (va_hi[4:2] == 3'd0)       region = RG_UNCACHED;  // 0xE0..0xE3 window
      else if (va_hi[4:0] == 5'd5)  region = RG_UNCACHED;  // 0xE5 window
      else                          region = RG_ERROR;
    end
  end

endmodule

// File: rtl/vat_tlb_array.sv
module vat_tlb_array
  import vat_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  tlb_entry_t        wr_data,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic              ext_mode,
  output logic              hit,
  output logic [PPN_W-1:0]  pa_page,
  output logic              hit_c,
  output logic              hit_wt
);

  tlb_entry_t                entry_q [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0]    hit_vec;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    logic        wr_sel;
    tlb_entry_t  entry_d;

    assign wr_sel = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      entry_d = entry_q[g];
      if (wr_sel) entry_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) entry_q[g] <= '0;
      else        entry_q[g] <= entry_d;
    end

    assign hit_vec[g] = entry_q[g].valid
                     && size_legal(entry_q[g].size, ext_mode)
                     && (((lk_vpn ^ entry_q[g].vpn) & vpn_mask(entry_q[g].size)) == '0);
  end

  // Lowest index wins: scan from the top down, last assignment sticks.
  always_comb begin
    logic [PPN_W-1:0]  sel_ppn;
    logic [SIZE_W-1:0] sel_size;
    logic [VPN_W-1:0]  sel_mask;
    sel_ppn  = '0;
    sel_size = '0;
    hit_c    = 1'b0;
    hit_wt   = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        sel_ppn  = entry_q[i].ppn;
        sel_size = entry_q[i].size;
        hit_c    = entry_q[i].c;
        hit_wt   = entry_q[i].wt;
      end
    end
    hit      = |hit_vec;
    sel_mask = vpn_mask(sel_size);
    pa_page  = (sel_ppn & sel_mask[PPN_W-1:0]) | (lk_vpn[PPN_W-1:0] & ~sel_mask[PPN_W-1:0]);
  end

endmodule

// File: rtl/vat_resp_build.sv
module vat_resp_build
  import vat_pkg::*;
(
  input  region_e           region,
  input  logic              xlate_en,
  input  logic              cache_en,
  input  logic              wt_global,
  input  logic [PA_W-1:0]   va_low,
  input  logic              hit,
  input  logic [PPN_W-1:0]  pa_page,
  input  logic              hit_c,
  input  logic              hit_wt,
  output logic [PA_W-1:0]   paddr,
  output logic              cacheable,
  output logic              wt,
  output logic              aerr,
  output logic              miss
);

  always_comb begin
    paddr     = '0;
    cacheable = 1'b0;
    wt        = 1'b0;
    aerr      = 1'b0;
    miss      = 1'b0;
    unique case (region)
      RG_XLATE: begin
        if (!xlate_en) begin
          paddr     = va_low;
          cacheable = cache_en;
          wt        = cache_en & wt_global;
        end else if (hit) begin
          paddr     = {pa_page, va_low[MIN_OFS-1:0]};
          cacheable = cache_en & hit_c;
          wt        = cache_en & hit_c & hit_wt;
        end else begin
          miss      = 1'b1;
        end
      end
      RG_CACHED: begin
        paddr     = va_low;
        cacheable = cache_en;
        wt        = cache_en & wt_global;
      end
      RG_UNCACHED: paddr = va_low;
      RG_ERROR:    aerr  = 1'b1;
    endcase
  end

endmodule

// File: rtl/va_xlate_unit.sv
module va_xlate_unit
  import vat_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_priv,
  input  logic              xlate_en,
  input  logic              ext_mode,
  input  logic              cache_en,
  input  logic              wt_global,
  input  logic              tlb_wr_en,
  input  logic [IDX_W-1:0]  tlb_wr_idx,
  input  logic              tlb_wr_valid,
  input  logic [VPN_W-1:0]  tlb_wr_vpn,
  input  logic [PPN_W-1:0]  tlb_wr_ppn,
  input  logic [SIZE_W-1:0] tlb_wr_size,
  input  logic              tlb_wr_c,
  input  logic              tlb_wr_wt,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_cacheable,
  output logic              rsp_wt,
  output logic              rsp_aerr,
  output logic              rsp_miss
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  region_e           region;
  tlb_entry_t        wr_data;
  logic              hit, hit_c, hit_wt;
  logic [PPN_W-1:0]  pa_page;
  logic [PA_W-1:0]   nx_paddr;
  logic              nx_c, nx_wt, nx_aerr, nx_miss;

  assign wr_data = '{valid: tlb_wr_valid, vpn: tlb_wr_vpn, ppn: tlb_wr_ppn,
                     size: tlb_wr_size, c: tlb_wr_c, wt: tlb_wr_wt};

  vat_region_dec u_region (
    .va_hi  (req_vaddr[VA_W-1:VA_W-8]),
    .priv   (req_priv),
    .region (region)
  );

  vat_tlb_array #(.NUM_ENTRIES(NUM_ENTRIES)) u_tlb (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (tlb_wr_en),
    .wr_idx   (tlb_wr_idx),
    .wr_data  (wr_data),
    .lk_vpn   (req_vaddr[VA_W-1:MIN_OFS]),
    .ext_mode (ext_mode),
    .hit      (hit),
    .pa_page  (pa_page),
    .hit_c    (hit_c),
    .hit_wt   (hit_wt)
  );

  vat_resp_build u_build (
    .region    (region),
    .xlate_en  (xlate_en),
    .cache_en  (cache_en),
    .wt_global (wt_global),
    .va_low    (req_vaddr[PA_W-1:0]),
    .hit       (hit),
    .pa_page   (pa_page),
    .hit_c     (hit_c),
    .hit_wt    (hit_wt),
    .paddr     (nx_paddr),
    .cacheable (nx_c),
    .wt        (nx_wt),
    .aerr      (nx_aerr),
    .miss      (nx_miss)
  );

  // Response register: next-state then flops, payload clock-enabled by req_valid.
  logic [PA_W-1:0] paddr_d;
  logic            c_d, wt_d, aerr_d, miss_d;

  always_comb begin
    paddr_d = rsp_paddr;
    c_d     = rsp_cacheable;
    wt_d    = rsp_wt;
    aerr_d  = rsp_aerr;
    miss_d  = rsp_miss;
    if (req_valid) begin
      paddr_d = nx_paddr;
      c_d     = nx_c;
      wt_d    = nx_wt;
      aerr_d  = nx_aerr;
      miss_d  = nx_miss;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid     <= 1'b0;
      rsp_paddr     <= '0;
      rsp_cacheable <= 1'b0;
      rsp_wt        <= 1'b0;
      rsp_aerr      <= 1'b0;
      rsp_miss      <= 1'b0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_paddr     <= paddr_d;
      rsp_cacheable <= c_d;
      rsp_wt        <= wt_d;
      rsp_aerr      <= aerr_d;
      rsp_miss      <= miss_d;
    end
  end

endmodule

// File: rtl/vat_checker.sv
module vat_checker
  import vat_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [VA_W-1:0] req_vaddr,
  input logic            req_priv,
  input logic            xlate_en,
  input logic            cache_en,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_cacheable,
  input logic            rsp_wt,
  input logic            rsp_aerr,
  input logic            rsp_miss
);

  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_fixed_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv && req_vaddr[31] && (req_vaddr[30:29] != 2'b10))
    |=> (rsp_paddr == $past(req_vaddr[PA_W-1:0])) && !rsp_aerr && !rsp_miss);

  p_uncached_p2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv && (req_vaddr[31:29] == 3'b101))
    |=> !rsp_cacheable && !rsp_wt);

  p_user_mid_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_priv && req_vaddr[31] && (req_vaddr[31:29] != 3'b111))
    |=> rsp_aerr);

  p_off_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !xlate_en && !req_vaddr[31])
    |=> (rsp_paddr == $past(req_vaddr[PA_W-1:0])) && (rsp_cacheable == $past(cache_en))
        && !rsp_miss && !rsp_aerr);

  p_wt_needs_c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_wt) |-> rsp_cacheable);

  p_miss_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> !rsp_aerr && !rsp_cacheable && (rsp_paddr == '0));

  p_err_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_aerr) |-> !rsp_miss && !rsp_cacheable && !rsp_wt && (rsp_paddr == '0));

endmodule

bind va_xlate_unit vat_checker chk_i (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .req_valid     (req_valid),
  .req_vaddr     (req_vaddr),
  .req_priv      (req_priv),
  .xlate_en      (xlate_en),
  .cache_en      (cache_en),
  .rsp_valid     (rsp_valid),
  .rsp_paddr     (rsp_paddr),
  .rsp_cacheable (rsp_cacheable),
  .rsp_wt        (rsp_wt),
  .rsp_aerr      (rsp_aerr),
  .rsp_miss      (rsp_miss)
);

// File: tb/va_xlate_unit_tb_top.sv
module va_xlate_unit_tb_top;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_priv = 1'b0;
  logic        xlate_en = 1'b0;
  logic        ext_mode = 1'b0;
  logic        cache_en = 1'b0;
  logic        wt_global = 1'b0;
  logic        tlb_wr_en = 1'b0;
  logic [2:0]  tlb_wr_idx = '0;
  logic        tlb_wr_valid = 1'b0;
  logic [21:0] tlb_wr_vpn = '0;
  logic [18:0] tlb_wr_ppn = '0;
  logic [2:0]  tlb_wr_size = '0;
  logic        tlb_wr_c = 1'b0;
  logic        tlb_wr_wt = 1'b0;
  logic        rsp_valid;
  logic [28:0] rsp_paddr;
  logic        rsp_cacheable, rsp_wt, rsp_aerr, rsp_miss;

  always #10 clk = ~clk;  // 50 MHz

  va_xlate_unit #(.NUM_ENTRIES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_priv(req_priv), .xlate_en(xlate_en), .ext_mode(ext_mode),
    .cache_en(cache_en), .wt_global(wt_global), .tlb_wr_en(tlb_wr_en),
    .tlb_wr_idx(tlb_wr_idx), .tlb_wr_valid(tlb_wr_valid), .tlb_wr_vpn(tlb_wr_vpn),
    .tlb_wr_ppn(tlb_wr_ppn), .tlb_wr_size(tlb_wr_size), .tlb_wr_c(tlb_wr_c),
    .tlb_wr_wt(tlb_wr_wt), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_cacheable(rsp_cacheable), .rsp_wt(rsp_wt), .rsp_aerr(rsp_aerr),
    .rsp_miss(rsp_miss)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference TLB, updated only from the bench's own writes.
  logic        m_valid [N];
  logic [21:0] m_vpn   [N];
  logic [18:0] m_ppn   [N];
  logic [2:0]  m_size  [N];
  logic        m_c     [N];
  logic        m_wt    [N];

  function automatic int m_bits(logic [2:0] code);
    int t[8] = '{10, 12, 13, 16, 18, 20, 22, 26};
    return t[code];
  endfunction

  // Expected result: {aerr, miss, cacheable, wt, paddr}; tag names the governing requirement.
  function automatic logic [32:0] model(input logic [31:0] va, input logic priv,
                                        input logic en, input logic ext, input logic ce,
                                        input logic wg, output string tag);
    logic [28:0] pa = va[28:0];
    if ((priv && (va < 32'h8000_0000 || (va >= 32'hC000_0000 && va < 32'hE000_0000)))
        || (!priv && va < 32'h8000_0000)) begin
      if (!en) begin
        tag = "R4";
        return {1'b0, 1'b0, ce, ce & wg, pa};
      end
      for (int i = 0; i < N; i++) begin
        if (m_valid[i] && (ext || m_size[i] == 0 || m_size[i] == 1 || m_size[i] == 3 || m_size[i] == 5)) begin
          int pb = m_bits(m_size[i]);
          logic [31:0] vb = {m_vpn[i], 10'b0};
          logic [31:0] pbase = {3'b0, m_ppn[i], 10'b0};
          if ((va >> pb) == (vb >> pb)) begin
            logic [31:0] p = ((pbase >> pb) << pb) | (va & ((32'd1 << pb) - 1));
            tag = "R5";
            return {1'b0, 1'b0, ce & m_c[i], ce & m_c[i] & m_wt[i], p[28:0]};
          end
        end
      end
      tag = "R8";
      return {1'b0, 1'b1, 1'b0, 1'b0, 29'd0};
    end
    if (priv) begin
      tag = "R2";
      if (va < 32'hA000_0000) return {1'b0, 1'b0, ce, ce & wg, pa};
      return {4'b0000, pa};
    end
    tag = "R3";
    if ((va >= 32'hE000_0000 && va < 32'hE400_0000) || (va >= 32'hE500_0000 && va < 32'hE600_0000))
      return {4'b0000, pa};
    return {1'b1, 3'b000, 29'd0};
  endfunction

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual {v,aerr,miss,c,wt,pa}=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge with inputs already set; checks the result one edge later.
  task automatic step(input string force_tag);
    logic [32:0] exp;
    string tag;
    exp = model(req_vaddr, req_priv, xlate_en, ext_mode, cache_en, wt_global, tag);
    if (force_tag != "") tag = force_tag;
    if (tlb_wr_en) begin
      m_valid[tlb_wr_idx] = tlb_wr_valid;
      m_vpn[tlb_wr_idx]   = tlb_wr_vpn;
      m_ppn[tlb_wr_idx]   = tlb_wr_ppn;
      m_size[tlb_wr_idx]  = tlb_wr_size;
      m_c[tlb_wr_idx]     = tlb_wr_c;
      m_wt[tlb_wr_idx]    = tlb_wr_wt;
    end
    if (req_valid) begin
      @(negedge clk);
      check(tag, {rsp_valid, rsp_aerr, rsp_miss, rsp_cacheable, rsp_wt, rsp_paddr}, {1'b1, exp});
    end else begin
      @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0) begin
        fails++;
        $display("FAIL R1: idle cycle rsp_valid actual=%b expected=0", rsp_valid);
      end
    end
    req_valid = 1'b0;
    tlb_wr_en = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic priv, input string tag);
    req_valid = 1'b1; req_vaddr = va; req_priv = priv;
    step(tag);
  endtask

  task automatic wr_set(input int idx, input logic v, input logic [31:0] va, input logic [28:0] pa,
                        input logic [2:0] sz, input logic c, input logic w);
    tlb_wr_en = 1'b1; tlb_wr_idx = idx[2:0]; tlb_wr_valid = v; tlb_wr_vpn = va[31:10];
    tlb_wr_ppn = pa[28:10]; tlb_wr_size = sz; tlb_wr_c = c; tlb_wr_wt = w;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_vpn[i] = '0; m_ppn[i] = '0; m_size[i] = '0; m_c[i] = 0; m_wt[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12: reset state of outputs
    check("R12", {rsp_valid, rsp_aerr, rsp_miss, rsp_cacheable, rsp_wt, rsp_paddr}, 34'd0);
    // R12: no entry valid after reset, so a translated lookup misses
    xlate_en = 1; ext_mode = 1; cache_en = 1; wt_global = 1;
    look(32'h0000_1000, 1'b1, "R12");

    // R2: fixed privileged regions
    look(32'h8123_4567, 1'b1, "R2");
    look(32'hA765_4321, 1'b1, "R2");
    look(32'hFF00_0010, 1'b1, "R2");
    cache_en = 0;
    look(32'h9000_0040, 1'b1, "R2");
    cache_en = 1;

    // R3: user-mode windows and errors
    look(32'h9000_0000, 1'b0, "R3");
    look(32'hD000_0000, 1'b0, "R3");
    look(32'hE100_0000, 1'b0, "R3");
    look(32'hE480_0000, 1'b0, "R3");
    look(32'hE5AB_CDEF, 1'b0, "R3");
    look(32'hF000_0000, 1'b0, "R3");

    // R11: error payload is clean
    look(32'hE7FF_FFFF, 1'b0, "R11");

    // R4: translation off
    xlate_en = 0; wt_global = 1;
    look(32'h7123_4567, 1'b0, "R4");
    look(32'hC0FF_EE00, 1'b1, "R4");
    xlate_en = 1;

    // R10: write and lookup in the same cycle sees old content, next cycle sees new
    wr_set(2, 1, 32'h0001_2000, 29'h0ABC_D000, 3'd1, 1, 1);
    req_valid = 1; req_vaddr = 32'h0001_2345; req_priv = 0;
    step("R10");
    look(32'h0001_2345, 1'b0, "R10");

    // R5: hit with C=1, WT=0, and global cache off
    wr_set(3, 1, 32'hC000_4000, 29'h0100_0000, 3'd0, 1, 0);
    step("R5");
    look(32'hC000_43FC, 1'b1, "R5");
    cache_en = 0;
    look(32'hC000_43FC, 1'b1, "R5");
    cache_en = 1;

    // R6: 64 MB page in extended mode
    wr_set(4, 1, 32'hC400_0000, 29'h1C00_0000, 3'd7, 1, 1);
    step("R6");
    look(32'hC7FF_FFFC, 1'b1, "R6");
    look(32'hC800_0000, 1'b1, "R6");

    // R7: 8 KB code is illegal in compatible mode
    wr_set(6, 1, 32'h0020_0000, 29'h0030_0000, 3'd2, 0, 0);
    step("R7");
    ext_mode = 0;
    look(32'h0020_1234, 1'b0, "R7");
    ext_mode = 1;
    look(32'h0020_1234, 1'b0, "R7");

    // R9: two matching entries, lowest index wins
    wr_set(5, 1, 32'h0050_0000, 29'h0111_0000, 3'd5, 1, 0);
    step("R9");
    wr_set(1, 1, 32'h0050_0000, 29'h0122_0000, 3'd3, 0, 0);
    step("R9");
    look(32'h0050_0ABC, 1'b0, "R9");
    look(32'h0058_0ABC, 1'b0, "R9");

    // R10: invalidation takes effect on the next lookup
    wr_set(2, 0, 32'h0001_2000, 29'h0ABC_D000, 3'd1, 1, 1);
    step("R10");
    look(32'h0001_2345, 1'b0, "R10");

    // R8: explicit miss
    look(32'h3333_0000, 1'b0, "R8");

    // R1: idle cycle
    step("R1");

    // Random mix
    for (int it = 0; it < 4000; it++) begin
      if ($urandom % 4 == 0) begin
        logic [31:0] wva = $urandom;
        if ($urandom % 2 == 0) wva[31:29] = 3'b110; else wva[31] = 1'b0;
        wr_set($urandom % N, ($urandom % 5) != 0, wva, 29'($urandom), 3'($urandom),
               1'($urandom), 1'($urandom));
      end
      req_valid = ($urandom % 8) != 0;
      if ($urandom % 2 == 0) begin
        int j = $urandom % N;
        req_vaddr = {m_vpn[j], 10'b0} ^ ($urandom & 32'h00FF_FFFF & ((32'd1 << ($urandom % 27)) - 1));
      end else begin
        req_vaddr = $urandom;
      end
      req_priv  = 1'($urandom);
      xlate_en  = ($urandom % 6) != 0;
      ext_mode  = 1'($urandom);
      cache_en  = 1'($urandom);
      wt_global = 1'($urandom);
      step("");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule